// File: doc/BRIEF.md
# Paged Step-Configuration Register Bank

This block holds the register state of a multi-step conversion sequencer. A host sees only a small address window. An 8-bit page pointer decides which page that window shows. Page 0 carries the general control byte and one enable bit per sequence step. Each page from 1 up to the step count holds the settings of one step: a configuration word and a conversion count. Page p belongs to step p-1.

The pointer sits at offset 0 of every page, so the host can always move to another page. Host access uses a plain synchronous read/write strobe pair, as a serial front end would drive it. Read data is registered.

A second port serves the sequencer. It takes a step index and returns that step's configuration word, conversion count and enable bit at once, whatever page the host has selected.

Top module: `seqpg_top`

## Requirements
- R1: After the asynchronous active-low reset, the pointer, every enable bit, the control byte, every step word, every count and the read data are zero.
- R2: Offset 0 reads back the pointer on every page, including pages above the step count. A write to offset 0 loads the pointer on every page.
- R3: On page 0, offsets 1 to 4 hold the step enable bits, eight steps per byte. Bit i of offset 1+k is the enable of step 8k+i. Offset 5 is a read/write control byte.
- R4: On page p, for p from 1 to 32, the registers belong to step p-1. Offset 1 is the configuration word bits 7:0 and offset 2 is bits 15:8. Offset 3 is the count bits 7:0. Bit 0 of offset 4 is count bit 8; the other bits of offset 4 read zero and are not stored.
- R5: While the pointer is above 32, reads at nonzero offsets return zero and writes at nonzero offsets change nothing.
- R6: Offsets not listed in R2 to R4 read zero, and writes to them change nothing. On page 0 these are offsets 6 to 15; on step pages they are offsets 5 to 15.
- R7: Read data shows the addressed byte one cycle after a read strobe. It holds its value while no read is strobed. A read and a write in the same cycle return the value from before the write.
- R8: The side port returns the word, count and enable of the indexed step in the same cycle, for any pointer value.
- R9: A write to a step page changes only that step's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Offset within the current page |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| page_o | output | 8 | Current page pointer |
| step_idx_i | input | 5 | Side-port step index |
| step_cfg_o | output | 16 | Configuration word of the indexed step |
| step_cnt_o | output | 9 | Conversion count of the indexed step |
| step_en_o | output | 1 | Enable bit of the indexed step |
| step_en_vec_o | output | 32 | All step enable bits |

## Verification
Random traffic mixes pointer moves with reads and writes at every offset. Most pointer values land in 0 to 34, which covers the general page, the step pages, both edges of the step range and the first page past it. The remaining pointer values are full random bytes.

Comparing reads at each pointer value shows whether the page decode is shifted by one step, cut off at the wrong edge, or aliased. Side-port reads taken while the pointer points elsewhere show whether a write reached the wrong step or the side port follows the pointer. Directed cases cover the reset contents, read-data hold, a read and a write in the same cycle, and writes aimed at pages above the step range.

// File: rtl/seqpg_pkg.sv
package seqpg_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 8;

  function automatic int bytes_of(input int w);
    return (w + DATA_W - 1) / DATA_W;
  endfunction
endpackage

// File: rtl/seqpg_ptr.sv
module seqpg_ptr
  import seqpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (we_i) ptr_o <= wdata_i;
  end
endmodule

// File: rtl/seqpg_field.sv
// Byte-lane register: W bits spread over consecutive offsets from BASE.
module seqpg_field
  import seqpg_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 4,
  parameter int BASE   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [W-1:0]      q_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int NB  = bytes_of(W);
  localparam int PAD = NB * DATA_W;

  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int LANE = j / DATA_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[j] <= 1'b0;
      else if (we_i && addr_i == ADDR_W'(BASE + LANE)) q_o[j] <= wdata_i[j % DATA_W];
    end
  end

  logic [PAD-1:0] padded;
  assign padded = PAD'(q_o);

  always_comb begin
    rd_o = '0;
    for (int b = 0; b < NB; b++)
      if (addr_i == ADDR_W'(BASE + b)) rd_o = padded[b*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/seqpg_top.sv
module seqpg_top
  import seqpg_pkg::*;
#(
  parameter int NUM_STEPS = 32,
  parameter int ADDR_W    = 4,
  parameter int CFG_W     = 16,
  parameter int CNT_W     = 9,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  page_o,
  input  logic [STEP_W-1:0] step_idx_i,
  output logic [CFG_W-1:0]  step_cfg_o,
  output logic [CNT_W-1:0]  step_cnt_o,
  output logic              step_en_o,
  output logic [NUM_STEPS-1:0] step_en_vec_o
);
  localparam int EN_BYTES  = bytes_of(NUM_STEPS);
  localparam int CTL_ADDR  = 1 + EN_BYTES;
  localparam int CFG_BASE  = 1;
  localparam int CNT_BASE  = CFG_BASE + bytes_of(CFG_W);

  logic ptr_hit, page_gen, page_step, gen_we, stp_we;
  logic [PTR_W-1:0]  step_page;
  logic [STEP_W-1:0] step_sel;

  assign ptr_hit   = (addr_i == '0);
  assign page_gen  = (page_o == '0);
  assign page_step = (page_o != '0) && (page_o <= PTR_W'(NUM_STEPS));
  assign step_page = page_o - PTR_W'(1);
  assign step_sel  = step_page[STEP_W-1:0];
  assign gen_we    = wr_i && !ptr_hit && page_gen;
  assign stp_we    = wr_i && !ptr_hit && page_step;

  seqpg_ptr u_ptr (
    .clk_i, .rst_ni,
    .we_i   (wr_i && ptr_hit),
    .wdata_i(wdata_i),
    .ptr_o  (page_o)
  );

  logic [DATA_W-1:0] en_rd, ctl_rd, ctl_q;

  seqpg_field #(.W(NUM_STEPS), .ADDR_W(ADDR_W), .BASE(1)) u_en (
    .clk_i, .rst_ni, .we_i(gen_we), .addr_i, .wdata_i,
    .q_o(step_en_vec_o), .rd_o(en_rd)
  );

  seqpg_field #(.W(DATA_W), .ADDR_W(ADDR_W), .BASE(CTL_ADDR)) u_ctl (
    .clk_i, .rst_ni, .we_i(gen_we), .addr_i, .wdata_i,
    .q_o(ctl_q), .rd_o(ctl_rd)
  );

  logic [CFG_W-1:0]  cfg_q  [NUM_STEPS];
  logic [CNT_W-1:0]  cnt_q  [NUM_STEPS];
  logic [DATA_W-1:0] step_rd[NUM_STEPS];

  for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step
    logic we_s;
    logic [DATA_W-1:0] cfg_rd, cnt_rd;
    assign we_s = stp_we && (step_sel == STEP_W'(s));

    seqpg_field #(.W(CFG_W), .ADDR_W(ADDR_W), .BASE(CFG_BASE)) u_cfg (
      .clk_i, .rst_ni, .we_i(we_s), .addr_i, .wdata_i,
      .q_o(cfg_q[s]), .rd_o(cfg_rd)
    );
    seqpg_field #(.W(CNT_W), .ADDR_W(ADDR_W), .BASE(CNT_BASE)) u_cnt (
      .clk_i, .rst_ni, .we_i(we_s), .addr_i, .wdata_i,
      .q_o(cnt_q[s]), .rd_o(cnt_rd)
    );
    assign step_rd[s] = cfg_rd | cnt_rd;
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    if (ptr_hit)        rd_next = page_o;
    else if (page_gen)  rd_next = en_rd | ctl_rd;
    else if (page_step) rd_next = step_rd[step_sel];
    else                rd_next = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_next;
  end

  assign step_cfg_o = cfg_q[step_idx_i];
  assign step_cnt_o = cnt_q[step_idx_i];
  assign step_en_o  = step_en_vec_o[step_idx_i];
endmodule

// File: rtl/seqpg_chk.sv
module seqpg_chk
  import seqpg_pkg::*;
#(
  parameter int NUM_STEPS = 32,
  parameter int ADDR_W    = 4,
  parameter int CFG_W     = 16,
  parameter int CNT_W     = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [PTR_W-1:0]     page_o,
  input logic [NUM_STEPS-1:0] step_en_vec_o
);
  localparam int GEN_LAST  = 1 + bytes_of(NUM_STEPS);
  localparam int STEP_LAST = bytes_of(CFG_W) + bytes_of(CNT_W);
  localparam int LAST      = (GEN_LAST > STEP_LAST) ? GEN_LAST : STEP_LAST;

  p_ptr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == '0) |=> page_o == $past(wdata_i));

  p_ptr_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == '0) |=> $stable(page_o));

  p_high_page_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != '0 && page_o > PTR_W'(NUM_STEPS)) |=> rdata_o == '0);

  p_high_page_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != '0 && page_o > PTR_W'(NUM_STEPS)) |=> $stable(step_en_vec_o));

  p_unmapped_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i > ADDR_W'(LAST)) |=> rdata_o == '0);

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind seqpg_top seqpg_chk #(
  .NUM_STEPS(NUM_STEPS), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .page_o(page_o),
  .step_en_vec_o(step_en_vec_o)
);

// File: tb/seqpg_top_bench.sv
`timescale 1ns/1ps
module seqpg_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, page;
  logic [4:0]  sidx = '0;
  logic [15:0] scfg;
  logic [8:0]  scnt;
  logic        sen;
  logic [31:0] env;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  seqpg_top u_seqpg_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .page_o(page),
    .step_idx_i(sidx), .step_cfg_o(scfg), .step_cnt_o(scnt),
    .step_en_o(sen), .step_en_vec_o(env)
  );

  logic [7:0]  m_ptr;
  logic [31:0] m_en;
  logic [7:0]  m_ctl;
  logic [15:0] m_cfg[32];
  logic [8:0]  m_cnt[32];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] pg, input logic [3:0] a);
    if (a == 0) return pg;
    if (pg == 0) begin
      if (a >= 1 && a <= 4) return m_en[8*(a-1) +: 8];
      if (a == 5) return m_ctl;
      return 8'h00;
    end
    if (pg <= 32) begin
      case (a)
        4'd1: return m_cfg[pg-1][7:0];
        4'd2: return m_cfg[pg-1][15:8];
        4'd3: return m_cnt[pg-1][7:0];
        4'd4: return {7'b0, m_cnt[pg-1][8]};
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] pg, input logic [3:0] a);
    if (a == 0) return "R2";
    if (pg > 32) return "R5";
    if (pg == 0) return (a <= 5) ? "R3" : "R6";
    return (a <= 4) ? "R4" : "R6";
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (a == 0) m_ptr = d;
    else if (m_ptr == 0) begin
      if (a >= 1 && a <= 4) m_en[8*(a-1) +: 8] = d;
      else if (a == 5) m_ctl = d;
    end else if (m_ptr <= 32) begin
      case (a)
        4'd1: m_cfg[m_ptr-1][7:0]  = d;
        4'd2: m_cfg[m_ptr-1][15:8] = d;
        4'd3: m_cnt[m_ptr-1][7:0]  = d;
        4'd4: m_cnt[m_ptr-1][8]    = d[0];
        default: ;
      endcase
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_rd(input logic [3:0] a);
    logic [7:0] e;
    string t;
    e = exp_rd(m_ptr, a);
    t = tag_of(m_ptr, a);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(t, rdata, e);
  endtask

  task automatic side_chk(input logic [4:0] s, input string tag);
    sidx = s;
    #1;
    chk({tag, " cfg"}, scfg, m_cfg[s]);
    chk({tag, " cnt"}, scnt, m_cnt[s]);
    chk({tag, " en"},  sen,  m_en[s]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] old;
    void'($urandom(32'd4711));
    m_ptr = 0; m_en = 0; m_ctl = 0;
    for (int i = 0; i < 32; i++) begin m_cfg[i] = 0; m_cnt[i] = 0; end

    repeat (3) @(negedge clk);
    // R1 reset contents
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 page", page, 8'h00);
    chk("R1 en_vec", env, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 32; s += 7) side_chk(5'(s), "R1");
    for (int a = 0; a < 16; a++) do_rd(4'(a));

    // R3 enable byte layout: step 9 is bit 1 of offset 2
    do_wr(4'd2, 8'h02);
    side_chk(5'd9, "R3");
    chk("R3 vec", env, 32'h0000_0200);
    do_wr(4'd5, 8'hA5);
    do_rd(4'd5);

    // R4 edge pages, count bit 8 only
    do_wr(4'd0, 8'd32);
    do_wr(4'd4, 8'hFF);
    do_wr(4'd1, 8'h3C);
    do_rd(4'd4);
    side_chk(5'd31, "R4");
    do_wr(4'd0, 8'd1);
    do_wr(4'd2, 8'h81);
    side_chk(5'd0, "R4");
    side_chk(5'd1, "R9");

    // R5 page above range: 33 and 200
    do_wr(4'd0, 8'd33);
    do_rd(4'd0);
    do_wr(4'd1, 8'hEE);
    do_rd(4'd1);
    do_wr(4'd0, 8'd200);
    do_wr(4'd2, 8'hFF);
    do_wr(4'd0, 8'd0);
    do_rd(4'd2);
    chk("R5 vec", env, m_en);

    // R6 unmapped on page 0
    do_wr(4'd9, 8'h77);
    do_rd(4'd9);

    // R7 hold without read, then read+write same cycle
    do_rd(4'd5);
    old = rdata;
    do_wr(4'd5, 8'h11);
    @(negedge clk);
    chk("R7 hold", rdata, old);
    addr = 4'd5; wdata = 8'h22; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk("R7 rd+wr", rdata, 8'h11);
    model_wr(4'd5, 8'h22);
    do_rd(4'd5);

    // Random traffic
    for (int it = 0; it < 3000; it++) begin
      int k;
      k = $urandom % 100;
      if (k < 15) begin
        if (($urandom % 10) < 8) do_wr(4'd0, 8'($urandom % 35));
        else                     do_wr(4'd0, 8'($urandom));
      end else if (k < 55) begin
        do_wr(4'($urandom % 7), 8'($urandom));
      end else begin
        do_rd(4'($urandom % 16));
      end
      // R8 side port independent of pointer; R9 isolation
      if ((it % 4) == 0) side_chk(5'($urandom), "R8/R9");
    end
    chk("R3 final vec", env, m_en);
    chk("R2 final page", page, m_ptr);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule